// File: doc/BRIEF.md
# Transmit DMA Start-Threshold Controller

This block is the control core of a buffered transmit DMA channel. It sits between a staging buffer, which collects frame words fetched from memory, and the transmit FIFO of a MAC. It decides when a frame may start moving out of the staging buffer. It then paces the move one word per cycle and steps a descriptor index around a ring whose size is a power of two. It also holds the channel's 32-bit control word, which is both written and read through a plain register port.

The control word has four fields. A ring-size code gives 2^n descriptors (`NBD`, bits 3:0). A start-level code gives eighths of the buffer depth (`LVL`, bits 6:4). An enable bit (`EN`, bit 10) and a self-clearing reset bit (`RST`, bit 11) complete it. Bit 9 is a spare storage bit with no function. A frame starts when the buffer fill reaches the programmed fraction, or at once when the frame's last word is already buffered. Once started, the frame runs to its end-of-frame word without the threshold being checked again.

The enable bit drops by itself when the current descriptor is not owned by the DMA. Data already buffered still drains after the channel is disabled.

The controller is built around five states, with these transitions:
- `ST_IDLE` goes to `ST_CHECK` when enabled.
- `ST_CHECK` inspects ownership. An owned descriptor leads to `ST_WAIT`. Otherwise the controller moves to `ST_DRAIN`, or to `ST_IDLE` if the buffer is empty.
- `ST_WAIT` holds until the start condition and goes to `ST_MOVE` on the start strobe. If enable drops, it leaves for `ST_DRAIN` or `ST_IDLE`.
- `ST_MOVE` returns to `ST_CHECK` after the end-of-frame word, or goes to `ST_DRAIN` if disabled meanwhile.
- `ST_DRAIN` goes to `ST_IDLE` once the buffer is empty.

A pending reset bit forces `ST_IDLE` from any state.

Top module: `txdma_start_ctrl`

## Requirements
- R1: After power-on reset the control word reads 0x00000000. Bits 8:7 and 31:12 always read zero, whatever was written to them.
- R2: The ring holds 2^NBD descriptors for NBD below 12. Every NBD of 12 or more gives 4096 descriptors. NBD=0 keeps the index at 0.
- R3: In `ST_WAIT` with a non-empty buffer and no end-of-frame word buffered, the start strobe rises in the same cycle that buf_level reaches DEPTH*L/8. L is the LVL code for codes 0 to 4, and codes 5 to 7 act as 4.
- R4: When buf_eof_present is high in `ST_WAIT` with a non-empty buffer, the start strobe fires whatever the LVL code and fill level.
- R5: move_start is a one-cycle pulse and never fires while the buffer is empty. After it, move_en is high in every cycle with a non-empty buffer until the end-of-frame word is moved. Falling fill is not rechecked in that time.
- R6: ring_idx advances by one, modulo the ring size, in the cycle after the end-of-frame word is moved.
- R7: When the descriptor being checked is not owned (desc_owned=0), EN clears by itself one cycle later and no transfer starts.
- R8: After EN is cleared, buffered data keeps moving (move_en high while non-empty) until the buffer is empty. No new start strobe occurs while disabled.
- R9: Writing RST=1 makes bit 11 read 1 for one cycle, with EN cleared. During that cycle move_en and move_start are low. On the next cycle bit 11 reads 0, ring_idx is 0 and the controller is idle.
- R10: If a software write lands in the same cycle as the automatic EN clear, all written fields are taken except EN, which reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Data to write to the control word |
| buf_level | input | LVL_W | Words held in the staging buffer (0..BUF_DEPTH) |
| buf_eof_present | input | 1 | Last word of the current frame is in the staging buffer |
| buf_head_eof | input | 1 | Word at the buffer head is the frame's last word |
| buf_empty | input | 1 | Staging buffer holds no word |
| desc_owned | input | 1 | Ownership flag of the current descriptor, 1 = DMA owns it |
| reg_rdata | output | 32 | Live control word |
| ring_idx | output | IDX_W | Current descriptor index |
| move_start | output | 1 | Frame transfer start strobe |
| move_en | output | 1 | Move one word from the buffer to the MAC FIFO this cycle |

## Verification
Two functions can fall into the same cycle. The automatic enable clear on a lost descriptor can coincide with a software write of the control word. The bench provokes this by enabling the channel with desc_owned low and timing a write of new fields plus EN=1 to land on the exact edge where `ST_CHECK` raises the clear. The case is judged by reading back all fields at once: the new LVL and NBD must appear while EN reads 0. A second overlap, a reset-bit write while a frame is mid-move, is judged by move_en dropping in the following cycle and ring_idx returning to zero.

// File: rtl/txdma_pkg.sv
`timescale 1ns/1ps
package txdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_MOVE,
        ST_DRAIN
    } tx_state_e;

    localparam int CTL_W      = 32;
    localparam int NBD_LSB    = 0;
    localparam int NBD_W      = 4;
    localparam int LVL_LSB    = 4;
    localparam int LVL_CODE_W = 3;
    localparam int SPARE_BIT  = 9;
    localparam int EN_BIT     = 10;
    localparam int RST_BIT    = 11;
    localparam int RING_LOG_MAX = 12;
    localparam int LVL_CAP      = 4;

    function automatic int start_eighths(input logic [LVL_CODE_W-1:0] code);
        return (int'(code) > LVL_CAP) ? LVL_CAP : int'(code);
    endfunction

    function automatic int ring_log(input logic [NBD_W-1:0] code);
        return (int'(code) > RING_LOG_MAX) ? RING_LOG_MAX : int'(code);
    endfunction

endpackage

// File: rtl/txdma_ctrl_reg.sv
`timescale 1ns/1ps
module txdma_ctrl_reg
    import txdma_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CTL_W-1:0]      wr_data,
    input  logic                  hw_clr_en,
    output logic [CTL_W-1:0]      ctl_word,
    output logic                  soft_rst,
    output logic                  en,
    output logic [NBD_W-1:0]      nbd,
    output logic [LVL_CODE_W-1:0] lvl_code
);

    logic [NBD_W-1:0]      nbd_q;
    logic [LVL_CODE_W-1:0] lvl_q;
    logic                  spare_q;
    logic                  en_q;
    logic                  rst_q;

    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[CTL_W-1:RST_BIT+1], wr_data[SPARE_BIT-1:LVL_LSB+LVL_CODE_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbd_q   <= '0;
            lvl_q   <= '0;
            spare_q <= 1'b0;
            en_q    <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            rst_q <= 1'b0;
            if (wr_en) begin
                nbd_q   <= wr_data[NBD_LSB +: NBD_W];
                lvl_q   <= wr_data[LVL_LSB +: LVL_CODE_W];
                spare_q <= wr_data[SPARE_BIT];
                en_q    <= wr_data[EN_BIT] & ~wr_data[RST_BIT];
                rst_q   <= wr_data[RST_BIT];
            end
            if (hw_clr_en) begin
                en_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctl_word = '0;
        ctl_word[NBD_LSB +: NBD_W]      = nbd_q;
        ctl_word[LVL_LSB +: LVL_CODE_W] = lvl_q;
        ctl_word[SPARE_BIT]             = spare_q;
        ctl_word[EN_BIT]                = en_q;
        ctl_word[RST_BIT]               = rst_q;
    end

    assign soft_rst = rst_q;
    assign en       = en_q;
    assign nbd      = nbd_q;
    assign lvl_code = lvl_q;

endmodule

// File: rtl/txdma_ring_idx.sv
`timescale 1ns/1ps
module txdma_ring_idx
    import txdma_pkg::*;
#(
    parameter int IDX_W = RING_LOG_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [NBD_W-1:0] size_code,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W:0]   span;
    logic [IDX_W-1:0] wrap_mask;
    logic [IDX_W-1:0] idx_q;
    int               lg;

    always_comb begin
        lg = ring_log(size_code);
        if (lg > IDX_W) begin
            lg = IDX_W;
        end
        span      = (IDX_W+1)'(1) << lg;
        wrap_mask = span[IDX_W-1:0] - IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= (idx_q + IDX_W'(1)) & wrap_mask;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/txdma_start_fsm.sv
`timescale 1ns/1ps
module txdma_start_fsm
    import txdma_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int LVL_W     = $clog2(BUF_DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  en,
    input  logic [LVL_CODE_W-1:0] lvl_code,
    input  logic [LVL_W-1:0]      buf_level,
    input  logic                  buf_eof_present,
    input  logic                  buf_head_eof,
    input  logic                  buf_empty,
    input  logic                  desc_owned,
    output logic                  move_start,
    output logic                  move_en,
    output logic                  ring_adv,
    output logic                  hw_clr_en
);

    tx_state_e        st_q;
    tx_state_e        st_d;
    logic [LVL_W-1:0] thr;
    logic             go;
    logic             last_out;

    always_comb begin
        thr = LVL_W'((BUF_DEPTH * start_eighths(lvl_code)) / 8);
    end

    assign go       = !buf_empty && (buf_eof_present || (buf_level >= thr));
    assign last_out = !buf_empty && buf_head_eof;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (en) begin
                    st_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!en || !desc_owned) begin
                    st_d = buf_empty ? ST_IDLE : ST_DRAIN;
                end else begin
                    st_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!en) begin
                    st_d = buf_empty ? ST_IDLE : ST_DRAIN;
                end else if (go) begin
                    st_d = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (last_out) begin
                    st_d = en ? ST_CHECK : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (buf_empty) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (soft_rst) begin
            st_d = ST_IDLE;
        end
    end

    always_comb begin
        move_start = 1'b0;
        move_en    = 1'b0;
        ring_adv   = 1'b0;
        hw_clr_en  = 1'b0;
        if (!soft_rst) begin
            unique case (st_q)
                ST_IDLE:  ;
                ST_CHECK: hw_clr_en = en && !desc_owned;
                ST_WAIT:  move_start = en && go;
                ST_MOVE: begin
                    move_en  = !buf_empty;
                    ring_adv = last_out;
                end
                ST_DRAIN: move_en = !buf_empty;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/txdma_start_ctrl.sv
`timescale 1ns/1ps
module txdma_start_ctrl
    import txdma_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int IDX_W     = RING_LOG_MAX,
    parameter int LVL_W     = $clog2(BUF_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [31:0]      reg_wr_data,
    input  logic [LVL_W-1:0] buf_level,
    input  logic             buf_eof_present,
    input  logic             buf_head_eof,
    input  logic             buf_empty,
    input  logic             desc_owned,
    output logic [31:0]      reg_rdata,
    output logic [IDX_W-1:0] ring_idx,
    output logic             move_start,
    output logic             move_en
);

    logic                  soft_rst;
    logic                  en;
    logic [NBD_W-1:0]      nbd;
    logic [LVL_CODE_W-1:0] lvl_code;
    logic                  hw_clr_en;
    logic                  ring_adv;

    txdma_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .hw_clr_en (hw_clr_en),
        .ctl_word  (reg_rdata),
        .soft_rst  (soft_rst),
        .en        (en),
        .nbd       (nbd),
        .lvl_code  (lvl_code)
    );

    txdma_start_fsm #(
        .BUF_DEPTH (BUF_DEPTH),
        .LVL_W     (LVL_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .soft_rst        (soft_rst),
        .en              (en),
        .lvl_code        (lvl_code),
        .buf_level       (buf_level),
        .buf_eof_present (buf_eof_present),
        .buf_head_eof    (buf_head_eof),
        .buf_empty       (buf_empty),
        .desc_owned      (desc_owned),
        .move_start      (move_start),
        .move_en         (move_en),
        .ring_adv        (ring_adv),
        .hw_clr_en       (hw_clr_en)
    );

    txdma_ring_idx #(
        .IDX_W (IDX_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .adv       (ring_adv),
        .size_code (nbd),
        .idx       (ring_idx)
    );

endmodule

// File: rtl/txdma_start_ctrl_chk.sv
`timescale 1ns/1ps
module txdma_start_ctrl_chk
    import txdma_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int IDX_W     = RING_LOG_MAX,
    parameter int LVL_W     = $clog2(BUF_DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      reg_rdata,
    input logic [IDX_W-1:0] ring_idx,
    input logic [LVL_W-1:0] buf_level,
    input logic             buf_eof_present,
    input logic             buf_empty,
    input logic             move_start,
    input logic             move_en
);

    logic [LVL_W-1:0] chk_thr;
    always_comb begin
        chk_thr = LVL_W'((BUF_DEPTH * start_eighths(reg_rdata[LVL_LSB +: LVL_CODE_W])) / 8);
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[8:7] == 2'b00) && (reg_rdata[31:12] == 20'h0)); // R1

    AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        move_start |-> (buf_eof_present || (buf_level >= chk_thr))); // R3

    AST_START_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        move_start |-> !buf_empty); // R5

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        move_start |=> !move_start); // R5

    AST_MOVE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        move_en |-> !buf_empty); // R8

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ring_idx) |-> ((ring_idx == '0) || ((ring_idx - $past(ring_idx)) == IDX_W'(1)))); // R6

    AST_RST_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RST_BIT] |-> (!reg_rdata[EN_BIT] && !move_en && !move_start)); // R9

    AST_RST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RST_BIT] |=> (ring_idx == '0)); // R9

endmodule

bind txdma_start_ctrl txdma_start_ctrl_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .IDX_W     (IDX_W),
    .LVL_W     (LVL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_rdata       (reg_rdata),
    .ring_idx        (ring_idx),
    .buf_level       (buf_level),
    .buf_eof_present (buf_eof_present),
    .buf_empty       (buf_empty),
    .move_start      (move_start),
    .move_en         (move_en)
);

// File: tb/txdma_start_ctrl_tb.sv
`timescale 1ns/1ps
module txdma_start_ctrl_tb;

    localparam int DEPTH = 64;
    localparam int IW    = 12;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [31:0]   reg_wr_data = '0;
    logic [LW-1:0] buf_level = '0;
    logic          buf_eof_present = 1'b0;
    logic          buf_head_eof = 1'b0;
    logic          buf_empty = 1'b1;
    logic          desc_owned = 1'b1;
    logic [31:0]   reg_rdata;
    logic [IW-1:0] ring_idx;
    logic          move_start;
    logic          move_en;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    txdma_start_ctrl #(.BUF_DEPTH(DEPTH)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_en       (reg_wr_en),
        .reg_wr_data     (reg_wr_data),
        .buf_level       (buf_level),
        .buf_eof_present (buf_eof_present),
        .buf_head_eof    (buf_head_eof),
        .buf_empty       (buf_empty),
        .desc_owned      (desc_owned),
        .reg_rdata       (reg_rdata),
        .ring_idx        (ring_idx),
        .move_start      (move_start),
        .move_en         (move_en)
    );

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic look();
        #0.5;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        nxt();
        reg_wr_en   = 1'b0;
    endtask

    task automatic quiet_inputs();
        buf_empty       = 1'b1;
        buf_level       = '0;
        buf_eof_present = 1'b0;
        buf_head_eof    = 1'b0;
        desc_owned      = 1'b1;
    endtask

    task automatic soft_reset();
        quiet_inputs();
        wr(32'h0000_0800);
        look();
        chk("R9 rst bit visible", {31'h0, reg_rdata[11]}, 32'h1);
        chk("R9 en cleared", {31'h0, reg_rdata[10]}, 32'h0);
        nxt();
        look();
        chk("R9 rst bit self-clears", reg_rdata, 32'h0);
        chk("R9 index zero", {20'h0, ring_idx}, 32'h0);
    endtask

    task automatic t_por();
        look();
        chk("R1 reset value", reg_rdata, 32'h0);
        chk("R1 reset index", {20'h0, ring_idx}, 32'h0);
        chk("R1 reset strobes", {30'h0, move_start, move_en}, 32'h0);
        wr(32'hFFFF_F3FF);
        look();
        chk("R1 reserved read zero", reg_rdata, 32'h0000_027F);
        soft_reset();
    endtask

    task automatic t_threshold(input int code);
        int thr;
        thr = (code > 4 ? 4 : code) * DEPTH / 8;
        soft_reset();
        if (thr == 0) begin
            buf_empty = 1'b1;
            buf_level = '0;
        end else begin
            buf_empty = 1'b0;
            buf_level = LW'(thr - 1);
        end
        wr(32'h0000_0402 | (32'(code) << 4));
        nxt();
        nxt();
        look();
        chk("R3 no start below level", {31'h0, move_start}, 32'h0);
        nxt();
        look();
        chk("R3 still waiting", {31'h0, move_start}, 32'h0);
        buf_empty = 1'b0;
        buf_level = LW'(thr == 0 ? 1 : thr);
        look();
        chk("R3 start at level", {31'h0, move_start}, 32'h1);
        nxt();
        buf_level = '0;
        look();
        chk("R5 start is a pulse", {31'h0, move_start}, 32'h0);
        chk("R5 moves without recheck", {31'h0, move_en}, 32'h1);
        nxt();
        buf_head_eof = 1'b1;
        look();
        chk("R5 moves eof word", {31'h0, move_en}, 32'h1);
        nxt();
        buf_head_eof = 1'b0;
        look();
        chk("R6 index advanced", {20'h0, ring_idx}, 32'h1);
    endtask

    task automatic t_eof_override();
        soft_reset();
        buf_empty       = 1'b0;
        buf_level       = LW'(3);
        buf_eof_present = 1'b1;
        wr(32'h0000_0442);
        nxt();
        nxt();
        look();
        chk("R4 eof forces start", {31'h0, move_start}, 32'h1);
        nxt();
        buf_head_eof = 1'b1;
        nxt();
    endtask

    task automatic t_ring();
        soft_reset();
        buf_empty       = 1'b0;
        buf_level       = LW'(1);
        buf_eof_present = 1'b1;
        buf_head_eof    = 1'b1;
        wr(32'h0000_0401);
        nxt();
        for (int i = 0; i < 3; i++) nxt();
        look();
        chk("R2 ring of 2 first step", {20'h0, ring_idx}, 32'h1);
        for (int i = 0; i < 3; i++) nxt();
        look();
        chk("R2 ring of 2 wraps", {20'h0, ring_idx}, 32'h0);
        soft_reset();
        buf_empty       = 1'b0;
        buf_level       = LW'(1);
        buf_eof_present = 1'b1;
        buf_head_eof    = 1'b1;
        wr(32'h0000_0400);
        nxt();
        for (int i = 0; i < 6; i++) nxt();
        look();
        chk("R2 ring of 1 stays zero", {20'h0, ring_idx}, 32'h0);
        soft_reset();
        buf_empty       = 1'b0;
        buf_level       = LW'(1);
        buf_eof_present = 1'b1;
        buf_head_eof    = 1'b1;
        wr(32'h0000_040D);
        nxt();
        for (int i = 0; i < 4095 * 3; i++) nxt();
        look();
        chk("R2 code 13 reaches 4095", {20'h0, ring_idx}, 32'hFFF);
        for (int i = 0; i < 3; i++) nxt();
        look();
        chk("R2 code 13 wraps at 4096", {20'h0, ring_idx}, 32'h0);
    endtask

    task automatic t_owner();
        soft_reset();
        desc_owned = 1'b0;
        buf_empty  = 1'b0;
        buf_level  = LW'(40);
        wr(32'h0000_0402);
        nxt();
        look();
        chk("R7 no start on foreign descriptor", {31'h0, move_start}, 32'h0);
        nxt();
        look();
        chk("R7 enable self-clears", reg_rdata, 32'h0000_0002);
        chk("R7 still no start", {31'h0, move_start}, 32'h0);
    endtask

    task automatic t_drain();
        soft_reset();
        buf_empty = 1'b0;
        buf_level = LW'(5);
        wr(32'h0000_0442);
        nxt();
        nxt();
        look();
        chk("R8 waiting below level", {31'h0, move_start}, 32'h0);
        wr(32'h0000_0042);
        look();
        chk("R8 no move yet", {31'h0, move_en}, 32'h0);
        nxt();
        look();
        chk("R8 drains after disable", {30'h0, move_start, move_en}, 32'h1);
        nxt();
        look();
        chk("R8 keeps draining", {31'h0, move_en}, 32'h1);
        buf_empty = 1'b1;
        look();
        chk("R8 stops at empty", {31'h0, move_en}, 32'h0);
        nxt();
        buf_empty = 1'b0;
        buf_level = LW'(40);
        nxt();
        look();
        chk("R8 no start while disabled", {30'h0, move_start, move_en}, 32'h0);
    endtask

    task automatic t_collision();
        soft_reset();
        desc_owned = 1'b0;
        wr(32'h0000_0402);
        nxt();
        wr(32'h0000_0432);
        look();
        chk("R10 clear beats write of enable", reg_rdata, 32'h0000_0032);
    endtask

    task automatic t_reset_mid();
        soft_reset();
        buf_empty       = 1'b0;
        buf_level       = LW'(1);
        buf_eof_present = 1'b1;
        wr(32'h0000_0402);
        nxt();
        nxt();
        look();
        chk("R9 setup start", {31'h0, move_start}, 32'h1);
        nxt();
        look();
        chk("R9 setup moving", {31'h0, move_en}, 32'h1);
        wr(32'h0000_0800);
        look();
        chk("R9 move halted by reset bit", {31'h0, move_en}, 32'h0);
        nxt();
        look();
        chk("R9 idle after reset", {reg_rdata[31:2], move_start, move_en}, 32'h0);
        chk("R9 index cleared", {20'h0, ring_idx}, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        quiet_inputs();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_por();
        for (int c = 0; c < 8; c++) t_threshold(c);
        t_eof_override();
        t_ring();
        t_owner();
        t_drain();
        t_collision();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule